// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five interrupt request lines for a small processor core and decides which one the core should service next. From highest to lowest rank they are a non-maskable trap, an edge-latched request, two level-sensed requests and a general request. Each line has its own trigger rule. Three of the lines have individual mask bits, all maskable lines share a global enable, and the trap bypasses every form of gating. The winning request is captured at an instruction boundary, and its fixed 16-bit vector address is held on registered outputs until the core acknowledges it.

The general request carries no fixed vector. When it wins, the controller drives an active-low acknowledge so that the core fetches the vector from elsewhere. Alongside the interrupt path, a small combinational helper turns a 3-bit software restart code into its restart address, which is the code multiplied by eight.

Top module: `irq_ctrl`

## Requirements
- R1: Priority, highest first, is trap (source code 0), edge request (code 1), upper level request (code 2), lower level request (code 3), general request (code 4). Only the highest-ranked live request is captured.
- R2: The captured vector is 0x0024 for the trap, 0x003C for the edge request, 0x0034 for the upper level request, 0x002C for the lower level request and 0x0000 for the general request. When nothing is presented, req_src reads 7 and req_vector reads 0.
- R3: The trap is captured whatever the masks and the global enable hold. It is live only after a rising edge on trap_in and only while trap_in is still high. After it is acknowledged it stays dead until trap_in goes low and rises again. A trap_in that is high through reset does not count as an edge.
- R4: A rising edge on r75_in sets a latch that persists after the input falls. The latch still sets while masked, and it is presented once unmasked. It is cleared by reset, by ien_clr and by acknowledging the edge request.
- R5: The upper and lower level requests are live only while their input is high, their mask bit is clear and the global enable is set.
- R6: The general request is live only while gen_in is high and the global enable is set. While it is presented, inta_n is low. inta_n is high at all other times.
- R7: Capturing any maskable request clears the global enable in the same edge. Capturing the trap leaves the global enable unchanged.
- R8: Capture happens only on a clock edge with boundary high and nothing presented. The outputs req_valid, req_vector and req_src then hold steady until ack is high on an edge, which clears them. A boundary seen while a request is presented is ignored.
- R9: rst_vector equals rst_code multiplied by 8, giving 0x0000 to 0x0038.
- R10: After reset, req_valid is 0, inta_n is 1, int_en is 0, all mask bits are 0, req_src is 7 and req_vector is 0.
- R11: A high mask_wr loads mask_val, where bit 2 masks the edge request, bit 1 masks the upper level request and bit 0 masks the lower level request (1 = masked). ien_set sets the global enable and ien_clr clears it, and ien_clr wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_in | input | 1 | Non-maskable trap request |
| r75_in | input | 1 | Edge-latched request |
| r65_in | input | 1 | Upper level-sensed request |
| r55_in | input | 1 | Lower level-sensed request |
| gen_in | input | 1 | General level-sensed request |
| mask_wr | input | 1 | Load strobe for the mask bits |
| mask_val | input | 3 | New mask bits (2: edge, 1: upper, 0: lower) |
| ien_set | input | 1 | Set the global enable |
| ien_clr | input | 1 | Clear the global enable and the edge latch |
| boundary | input | 1 | Instruction boundary sample strobe |
| ack | input | 1 | Core acknowledge of the presented request |
| rst_code | input | 3 | Software restart code |
| req_valid | output | 1 | A request is presented |
| req_vector | output | 16 | Vector address of the presented request |
| req_src | output | 3 | Source code of the presented request, 7 when idle |
| inta_n | output | 1 | Active-low acknowledge for the general request |
| int_en | output | 1 | Global enable state |
| rst_vector | output | 16 | Restart address for rst_code |

## Verification
The assertions assume that the core raises ack only while req_valid is high and that boundary comes as single-cycle strobes. They also assume that, in any cycle where the edge request is acknowledged, r75_in does not rise. The stimulus holds each request input steady across the capture edge and sets inputs shortly after a rising edge. It pulses boundary for exactly one cycle, and it acknowledges only after it has seen a presented request. Edge-latch pulses are placed away from ack cycles, so the order between setting and clearing the latch is never exercised.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 5;
    localparam int VEC_W = 16;

    typedef enum logic [2:0] {
        SRC_TRAP = 3'd0,
        SRC_R75  = 3'd1,
        SRC_R65  = 3'd2,
        SRC_R55  = 3'd3,
        SRC_GEN  = 3'd4,
        SRC_NONE = 3'd7
    } src_e;

    // Fixed vector per source; general request gets its vector from the core.
    function automatic logic [VEC_W-1:0] src_vector(src_e s);
        case (s)
            SRC_TRAP: return VEC_W'(16'h0024);
            SRC_R75:  return VEC_W'(16'h003C);
            SRC_R65:  return VEC_W'(16'h0034);
            SRC_R55:  return VEC_W'(16'h002C);
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/irq_trigger.sv
module irq_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic trap_in,
    input  logic r75_in,
    input  logic ien_clr,
    input  logic ack_trap,
    input  logic ack_r75,
    output logic trap_live,
    output logic r75_latched
);
    typedef struct packed {
        logic trap_prev;
        logic trap_pend;
        logic r75_prev;
        logic r75_lat;
    } trig_t;

    trig_t st_q, st_d;
    logic  trap_rise, r75_rise;

    always_comb begin
        st_d      = st_q;
        trap_rise = trap_in & ~st_q.trap_prev;
        r75_rise  = r75_in & ~st_q.r75_prev;

        st_d.trap_prev = trap_in;
        st_d.r75_prev  = r75_in;

        // Trap qualifies on an edge and dies when the level drops or on ack.
        if (!trap_in)
            st_d.trap_pend = 1'b0;
        else if (trap_rise)
            st_d.trap_pend = 1'b1;
        else if (ack_trap)
            st_d.trap_pend = 1'b0;

        if (r75_rise)
            st_d.r75_lat = 1'b1;
        else if (ien_clr || ack_r75)
            st_d.r75_lat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.trap_prev <= 1'b1;
            st_q.trap_pend <= 1'b0;
            st_q.r75_prev  <= 1'b1;
            st_q.r75_lat   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_live   = st_q.trap_pend & trap_in;
    assign r75_latched = st_q.r75_lat;

    assert_trap_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_in |=> !trap_live);

    assert_r75_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_clr && !(r75_in && !$past(r75_in))) |=> !r75_latched)
        else $error("edge latch survived disable");
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any,
    output src_e         win
);
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_rank
        assign gnt[i]       = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    assign any = blocked[N];

    always_comb begin
        win = SRC_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (gnt[i]) win = src_e'(3'(i));
        end
    end

    assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (any == (req != '0)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int RST_CODE_W = 3,
    parameter int RST_STRIDE = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trap_in,
    input  logic                  r75_in,
    input  logic                  r65_in,
    input  logic                  r55_in,
    input  logic                  gen_in,
    input  logic                  mask_wr,
    input  logic [2:0]            mask_val,
    input  logic                  ien_set,
    input  logic                  ien_clr,
    input  logic                  boundary,
    input  logic                  ack,
    input  logic [RST_CODE_W-1:0] rst_code,
    output logic                  req_valid,
    output logic [VEC_W-1:0]      req_vector,
    output logic [2:0]            req_src,
    output logic                  inta_n,
    output logic                  int_en,
    output logic [VEC_W-1:0]      rst_vector
);
    localparam int RST_SHIFT = $clog2(RST_STRIDE);

    typedef struct packed {
        logic [2:0]       mask;
        logic             ien;
        logic             valid;
        logic [VEC_W-1:0] vec;
        src_e             src;
        logic             inta_n;
    } ctl_t;

    ctl_t       q, d;
    logic       trap_live, r75_latched;
    logic [NSRC-1:0] req, gnt;
    logic       any;
    src_e       win;
    logic       accept, ack_fire;

    assign ack_fire = ack & q.valid;

    irq_trigger u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_in     (trap_in),
        .r75_in      (r75_in),
        .ien_clr     (ien_clr),
        .ack_trap    (ack_fire && q.src == SRC_TRAP),
        .ack_r75     (ack_fire && q.src == SRC_R75),
        .trap_live   (trap_live),
        .r75_latched (r75_latched)
    );

    assign req[0] = trap_live;
    assign req[1] = r75_latched & ~q.mask[2] & q.ien;
    assign req[2] = r65_in & ~q.mask[1] & q.ien;
    assign req[3] = r55_in & ~q.mask[0] & q.ien;
    assign req[4] = gen_in & q.ien;

    irq_resolve #(.N(NSRC)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt),
        .any   (any),
        .win   (win)
    );

    assign accept = boundary & ~q.valid & any;

    always_comb begin
        d = q;
        if (mask_wr) d.mask = mask_val;
        if (ien_set) d.ien = 1'b1;
        if (ien_clr) d.ien = 1'b0;

        if (ack_fire) begin
            d.valid  = 1'b0;
            d.vec    = '0;
            d.src    = SRC_NONE;
            d.inta_n = 1'b1;
        end else if (accept) begin
            d.valid  = 1'b1;
            d.vec    = src_vector(win);
            d.src    = win;
            d.inta_n = (win != SRC_GEN);
            if (win != SRC_TRAP) d.ien = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mask   <= '0;
            q.ien    <= 1'b0;
            q.valid  <= 1'b0;
            q.vec    <= '0;
            q.src    <= SRC_NONE;
            q.inta_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_valid  = q.valid;
    assign req_vector = q.vec;
    assign req_src    = q.src;
    assign inta_n     = q.inta_n;
    assign int_en     = q.ien;
    assign rst_vector = VEC_W'({rst_code, {RST_SHIFT{1'b0}}});

    assert_trap_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !req_valid && trap_live) |=> (req_valid && req_src == SRC_TRAP));

    assert_hold_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack) |=> (req_valid && $stable(req_vector) && $stable(req_src)));

    assert_inta_only_gen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n |-> (req_valid && req_src == SRC_GEN));

    assert_ien_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !req_valid && any && !gnt[0]) |=> !int_en);

    assert_edge_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == SRC_R75) |-> req_vector == 16'h003C);
endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic trap_in = 0, r75_in = 0, r65_in = 0, r55_in = 0, gen_in = 0;
    logic mask_wr = 0, ien_set = 0, ien_clr = 0, boundary = 0, ack = 0;
    logic [2:0] mask_val = 0, rst_code = 0;
    logic req_valid, inta_n, int_en;
    logic [15:0] req_vector, rst_vector;
    logic [2:0] req_src;

    int total = 0, bad = 0;
    string cur_tag = "R10";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .r75_in(r75_in),
        .r65_in(r65_in), .r55_in(r55_in), .gen_in(gen_in),
        .mask_wr(mask_wr), .mask_val(mask_val), .ien_set(ien_set),
        .ien_clr(ien_clr), .boundary(boundary), .ack(ack),
        .rst_code(rst_code), .req_valid(req_valid), .req_vector(req_vector),
        .req_src(req_src), .inta_n(inta_n), .int_en(int_en),
        .rst_vector(rst_vector)
    );

    // ---------------- behavioural reference ----------------
    bit m_tprev, m_tpend, m_eprev, m_elat, m_ien, m_valid, m_inta;
    bit [2:0] m_mask;
    int m_src, m_vec;

    function automatic int vec_of(int s);
        case (s)
            0: return 'h24;
            1: return 'h3C;
            2: return 'h34;
            3: return 'h2C;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tprev = 1; m_tpend = 0; m_eprev = 1; m_elat = 0;
            m_ien = 0; m_valid = 0; m_inta = 1; m_mask = 0;
            m_src = 7; m_vec = 0;
        end else begin
            bit live[5];
            int w;
            bit acked, n_tpend, n_elat, n_ien;
            live[0] = m_tpend && trap_in;
            live[1] = m_elat && !m_mask[2] && m_ien;
            live[2] = r65_in && !m_mask[1] && m_ien;
            live[3] = r55_in && !m_mask[0] && m_ien;
            live[4] = gen_in && m_ien;
            w = -1;
            for (int i = 4; i >= 0; i--) if (live[i]) w = i;
            acked = ack && m_valid;

            n_tpend = m_tpend;
            if (!trap_in) n_tpend = 0;
            else if (!m_tprev) n_tpend = 1;
            else if (acked && m_src == 0) n_tpend = 0;

            n_elat = m_elat;
            if (r75_in && !m_eprev) n_elat = 1;
            else if (ien_clr || (acked && m_src == 1)) n_elat = 0;

            n_ien = ien_clr ? 0 : (ien_set ? 1 : m_ien);
            if (mask_wr) m_mask = mask_val;

            if (acked) begin
                m_valid = 0; m_src = 7; m_vec = 0; m_inta = 1;
            end else if (boundary && !m_valid && w >= 0) begin
                m_valid = 1; m_src = w; m_vec = vec_of(w); m_inta = (w != 4);
                if (w != 0) n_ien = 0;
            end
            m_tprev = trap_in; m_eprev = r75_in;
            m_tpend = n_tpend; m_elat = n_elat; m_ien = n_ien;
        end
    end

    task automatic chk(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_tag, req_valid, m_valid, "valid");
            chk(cur_tag, req_vector, m_vec, "vector");
            chk(cur_tag, req_src, m_src, "src");
            chk(cur_tag, inta_n, m_inta, "inta_n");
            chk(cur_tag, int_en, m_ien, "int_en");
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe_boundary();
        boundary = 1; tick(); boundary = 0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic enable();
        ien_set = 1; tick(); ien_set = 0;
    endtask

    task automatic set_mask(logic [2:0] m);
        mask_val = m; mask_wr = 1; tick(); mask_wr = 0;
    endtask

    task automatic expect_out(string tag, int v, int vec, int src, int ia);
        @(negedge clk);
        chk(tag, req_valid, v, "valid");
        chk(tag, req_vector, vec, "vector");
        chk(tag, req_src, src, "src");
        chk(tag, inta_n, ia, "inta_n");
        tick();
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R10 reset state
        @(negedge clk);
        chk("R10", req_valid, 0, "valid"); chk("R10", inta_n, 1, "inta_n");
        chk("R10", int_en, 0, "int_en"); chk("R10", req_src, 7, "src");
        chk("R10", req_vector, 0, "vector");
        tick();

        // R9 restart vectors
        cur_tag = "R9";
        for (int c = 0; c < 8; c++) begin
            rst_code = 3'(c); #1;
            chk("R9", rst_vector, c * 8, "rst_vector");
        end

        // R3 trap ignores masks and enable
        cur_tag = "R3";
        set_mask(3'b111);
        trap_in = 1; tick();
        strobe_boundary();
        expect_out("R3", 1, 'h24, 0, 1);
        chk("R7", int_en, 0, "int_en after trap");
        do_ack();
        strobe_boundary();            // trap still high, not re-armed
        expect_out("R3", 0, 0, 7, 1);
        trap_in = 0; tick();
        trap_in = 1; tick(); trap_in = 0; tick();  // edge then drop
        strobe_boundary();
        expect_out("R3", 0, 0, 7, 1);

        // R5 / R1 / R7 / R11 level requests
        cur_tag = "R5";
        set_mask(3'b000);
        enable();
        r65_in = 1; r55_in = 1; tick();
        strobe_boundary();
        expect_out("R1", 1, 'h34, 2, 1);
        chk("R7", int_en, 0, "int_en after maskable");
        do_ack();
        r65_in = 0; enable();
        strobe_boundary();
        expect_out("R5", 1, 'h2C, 3, 1);
        do_ack();
        set_mask(3'b001); enable();
        strobe_boundary();
        expect_out("R11", 0, 0, 7, 1);
        r55_in = 0; set_mask(3'b000);

        // R11 clear beats set
        cur_tag = "R11";
        ien_set = 1; ien_clr = 1; tick(); ien_set = 0; ien_clr = 0;
        @(negedge clk); chk("R11", int_en, 0, "clr wins"); tick();

        // R4 edge latch
        cur_tag = "R4";
        enable();
        r75_in = 1; tick(); r75_in = 0; tick(2);
        strobe_boundary();
        expect_out("R4", 1, 'h3C, 1, 1);
        do_ack(); enable();
        strobe_boundary();
        expect_out("R4", 0, 0, 7, 1);
        r75_in = 1; tick(); r75_in = 0; tick();
        ien_clr = 1; tick(); ien_clr = 0; enable();
        strobe_boundary();
        expect_out("R4", 0, 0, 7, 1);
        set_mask(3'b100);
        r75_in = 1; tick(); r75_in = 0; tick();
        strobe_boundary();
        expect_out("R4", 0, 0, 7, 1);
        set_mask(3'b000);
        strobe_boundary();
        expect_out("R4", 1, 'h3C, 1, 1);
        do_ack();

        // R6 general request
        cur_tag = "R6";
        gen_in = 1; tick();
        strobe_boundary();            // enable is clear
        expect_out("R6", 0, 0, 7, 1);
        enable();
        strobe_boundary();
        expect_out("R6", 1, 0, 4, 0);

        // R8 hold while presented, extra boundary ignored
        cur_tag = "R8";
        trap_in = 1; tick();
        strobe_boundary();
        tick(3);
        expect_out("R8", 1, 0, 4, 0);
        do_ack();
        expect_out("R6", 0, 0, 7, 1);
        gen_in = 0;

        // R1 everything at once: trap first, then edge request
        cur_tag = "R1";
        trap_in = 0; tick();
        enable();
        r75_in = 1; trap_in = 1; r65_in = 1; r55_in = 1; gen_in = 1; tick();
        strobe_boundary();
        expect_out("R1", 1, 'h24, 0, 1);
        chk("R7", int_en, 1, "trap keeps enable");
        do_ack();
        strobe_boundary();
        expect_out("R1", 1, 'h3C, 1, 1);
        do_ack();
        r75_in = 0; trap_in = 0; r65_in = 0; r55_in = 0; gen_in = 0;
        tick(2);

        // R2 reset while presented returns outputs to idle
        cur_tag = "R2";
        enable(); r55_in = 1; tick();
        strobe_boundary();
        expect_out("R2", 1, 'h2C, 3, 1);
        rst_n = 0; #1;
        chk("R10", req_valid, 0, "valid in reset");
        chk("R10", req_src, 7, "src in reset");
        tick(); rst_n = 1; r55_in = 0; tick(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule